// File: doc/BRIEF.md
# Double-buffered UART transmitter

This block serializes bytes onto an asynchronous serial line. A byte written by the host first lands in a one-entry holding register. A separate shift register takes it out of there as soon as the shifter can accept it. While one byte is being shifted out, the host can therefore queue the next one, and consecutive frames leave the block back to back.

Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line rests high between frames. A reloadable down-counter sets the bit period to `cfg_div + 1` clock cycles. A ready flag tells the host that the holding register has room. An empty flag tells it that the shifter is idle and the line is at rest. A sticky overrun flag records any write that was refused.

The handoff from the holding register into the shifter can coincide with the baud tick that ends a stop bit, and a host write can land in that same cycle. The block chooses the handoff byte and its valid bit as one unit. Such a write is sent exactly once, with its start bit directly after the stop bit, and no stray zero frame is ever produced.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `tx_empty` is 1 and `overrun` is 0.
- R2: A frame on `txd` is a 0 start bit, then the eight data bits from bit 0 up to bit 7, then a 1 stop bit. Whenever no frame is in progress, `txd` is 1.
- R3: Every bit of a frame lasts `cfg_div + 1` clock cycles. A write sampled at clock edge E while the transmitter is empty drives the start bit onto `txd` from edge E onward.
- R4: `tx_empty` falls at the edge that samples a write to the empty transmitter. It rises again at the edge 10 × (`cfg_div` + 1) cycles later, at the end of the last stop bit.
- R5: A write accepted while a frame is in progress is held, which drives `tx_ready` to 0. `tx_ready` is 1 whenever `tx_empty` is 1.
- R6: When a byte waits in the holding register, `tx_ready` returns to 1 at the start of the current frame's stop bit. That is 9 bit periods after the frame's start edge.
- R7: A queued byte begins its start bit at the edge that ends the previous stop bit, with no idle cycle in between.
- R8: A write sampled while `tx_ready` is 0 is discarded and never transmitted. It sets `overrun`, which stays 1 until reset.
- R9: A write sampled in any cycle of a stop bit while nothing is queued is transmitted exactly once. This includes the cycle in which the stop bit ends on a baud tick. Its start bit begins at the edge that ends that stop bit, and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Bit period minus one, in clock cycles |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Holding register free to accept a write |
| tx_empty | output | 1 | Shifter idle, line at rest |
| overrun | output | 1 | Sticky: a write was discarded |

## Verification
All state is registered, so `txd` shows the start bit after the same edge that samples the write, when the transmitter was empty. Every later bit switches exactly `cfg_div + 1` edges after the one before. `tx_ready` rises at edge 9 × (`cfg_div` + 1) and `tx_empty` at edge 10 × (`cfg_div` + 1), both counted from the frame's start edge. `overrun` changes at the edge that samples the refused write. The bench counts clock edges from reset. It predicts the start edge of every frame before it makes any write, then compares `txd` and the flags at the falling edge after each predicted edge, across whole frames. The stop-bit handoff is swept over every write offset from the second cycle of the stop bit up to two cycles after it ends, and each expected start edge is computed from that offset.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned BITCNT_W = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] tx_data_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    // A byte offered to the shifter: valid and data always travel together.
    typedef struct packed {
        logic     valid;
        tx_data_t data;
    } tx_byte_t;

    function automatic logic line_level(tx_state_e st, logic lsb);
        case (st)
            ST_START: return 1'b0;
            ST_DATA:  return lsb;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart || cnt_q == '0) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = (cnt_q == '0) && !restart;

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  tx_data_t wr_data,
    input  logic     take,
    output tx_byte_t offer,
    output logic     full,
    output logic     overrun
);

    tx_data_t data_q;
    logic     full_q;
    logic     ovr_q;

    // A stored byte has priority; otherwise a write in flight is offered directly.
    always_comb begin
        offer.valid = full_q | wr_en;
        offer.data  = full_q ? data_q : wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (full_q) begin
            if (take)  full_q <= 1'b0;
            if (wr_en) ovr_q  <= 1'b1;
        end else if (wr_en && !take) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end
    end

    assign full    = full_q;
    assign overrun = ovr_q;

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  tx_byte_t  offer,
    output logic      take,
    output logic      restart,
    output logic      txd,
    output tx_state_e state,
    output logic      queued
);

    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(DATA_W - 1);

    tx_state_e            state_q;
    tx_data_t             sr_q;
    logic [BITCNT_W-1:0]  bit_q;
    logic                 queued_q;
    logic                 last_bit;
    logic                 free;

    assign last_bit = (state_q == ST_DATA) && tick && (bit_q == LAST_BIT);
    assign free     = (state_q == ST_IDLE)
                    | ((state_q == ST_STOP) && !queued_q)
                    | last_bit;
    assign take     = free && offer.valid;
    assign restart  = (state_q == ST_IDLE) && offer.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            sr_q     <= '0;
            bit_q    <= '0;
            queued_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (offer.valid) begin
                        sr_q     <= offer.data;
                        state_q  <= ST_START;
                        queued_q <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        state_q <= ST_DATA;
                        bit_q   <= '0;
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == LAST_BIT) begin
                            state_q  <= ST_STOP;
                            queued_q <= offer.valid;
                            if (offer.valid) sr_q <= offer.data;
                        end else begin
                            sr_q <= sr_q >> 1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (queued_q) begin
                            state_q  <= ST_START;
                            queued_q <= 1'b0;
                        end else if (offer.valid) begin
                            state_q <= ST_START;
                            sr_q    <= offer.data;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else if (!queued_q && offer.valid) begin
                        queued_q <= 1'b1;
                        sr_q     <= offer.data;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign txd    = line_level(state_q, sr_q[0]);
    assign state  = state_q;
    assign queued = queued_q;

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import uart_tx_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              overrun
);

    tx_byte_t  offer;
    tx_state_e sh_state;
    logic      take;
    logic      restart;
    logic      baud_tick;
    logic      hold_full;
    logic      sh_queued;

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .reload  (cfg_div),
        .tick    (baud_tick)
    );

    uart_tx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .offer   (offer),
        .full    (hold_full),
        .overrun (overrun)
    );

    uart_tx_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (baud_tick),
        .offer   (offer),
        .take    (take),
        .restart (restart),
        .txd     (txd),
        .state   (sh_state),
        .queued  (sh_queued)
    );

    assign tx_ready = !hold_full;
    assign tx_empty = (sh_state == ST_IDLE);

endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk
    import uart_tx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      wr_en,
    input logic      txd,
    input logic      tx_ready,
    input logic      tx_empty,
    input logic      overrun,
    input tx_state_e state,
    input logic      tick,
    input logic      queued,
    input logic      offer_valid
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd); // R2

    AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> txd); // R2

    AST_START_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && wr_en) |=> (!txd && !tx_empty)); // R3

    AST_EMPTY_IMPLIES_READY: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_ready); // R5

    AST_READY_AT_STOP_START: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_ready) |-> (state == ST_STOP && $past(state) == ST_DATA)); // R6

    AST_QUEUED_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && tick && queued) |=> (state == ST_START)); // R7

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !tx_ready) |=> overrun); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R8

    AST_COINCIDENT_WRITE_SENT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && tick && !queued && wr_en) |=> (state == ST_START && !txd)); // R9

    AST_NO_EXTRA_FRAME: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && tick && !queued && !offer_valid) |=> tx_empty); // R9

endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .txd         (txd),
    .tx_ready    (tx_ready),
    .tx_empty    (tx_empty),
    .overrun     (overrun),
    .state       (sh_state),
    .tick        (baud_tick),
    .queued      (sh_queued),
    .offer_valid (offer.valid)
);

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_div = 16'd3;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        txd;
    logic        tx_ready;
    logic        tx_empty;
    logic        overrun;

    int edge_no = 0;
    int checks  = 0;
    int fails   = 0;

    uart_tx_dbuf u_uart_tx_dbuf (
        .clk      (clk),
        .rst      (rst),
        .cfg_div  (cfg_div),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .txd      (txd),
        .tx_ready (tx_ready),
        .tx_empty (tx_empty),
        .overrun  (overrun)
    );

    always #4 clk = ~clk;

    always @(posedge clk) edge_no <= edge_no + 1;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
        summary();
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int div);
        @(negedge clk);
        rst     = 1'b1;
        cfg_div = 16'(div);
        wr_en   = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_edge(input int e);
        while (edge_no != e) @(negedge clk);
    endtask

    // Drive a write sampled at edge e; returns at the negedge after e.
    task automatic write_at(input int e, input logic [7:0] v);
        wait_edge(e - 1);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Frame with start edge s and bit period n, compared cycle by cycle.
    task automatic check_frame(input logic [7:0] v, input int s, input int n,
                               input string req);
        int bad = 0;
        for (int k = 0; k < 10 * n; k++) begin
            int   slot = k / n;
            logic exp_bit;
            wait_edge(s + k);
            if (slot == 0)      exp_bit = 1'b0;
            else if (slot <= 8) exp_bit = v[slot-1];
            else                exp_bit = 1'b1;
            if (txd !== exp_bit) bad++;
        end
        check(bad == 0, req, $sformatf("frame 0x%02h cycles wrong", v), bad, 0);
    endtask

    task automatic check_idle(input int s, input int len, input string req);
        int bad = 0;
        for (int k = 0; k < len; k++) begin
            wait_edge(s + k);
            if (txd !== 1'b1 || tx_empty !== 1'b1) bad++;
        end
        check(bad == 0, req, "idle cycles wrong", bad, 0);
    endtask

    initial begin : main
        int s;
        int n;

        // R1: reset state
        do_reset(3);
        check(txd == 1'b1,      "R1", "txd",      int'(txd),      1);
        check(tx_ready == 1'b1, "R1", "tx_ready", int'(tx_ready), 1);
        check(tx_empty == 1'b1, "R1", "tx_empty", int'(tx_empty), 1);
        check(overrun == 1'b0,  "R1", "overrun",  int'(overrun),  0);

        // R2 R3 R4: single frames over a sweep of divisors
        for (int d = 0; d < 6; d++) begin
            logic [7:0] v;
            v = 8'h5A ^ 8'(d * 37);
            n = d + 1;
            do_reset(d);
            s = edge_no + 1;
            write_at(s, v);
            check(tx_empty == 1'b0, "R4", "tx_empty at write edge", int'(tx_empty), 0);
            check_frame(v, s, n, "R2_R3");
            wait_edge(s + 10 * n - 1);
            check(tx_empty == 1'b0, "R4", "tx_empty in last stop cycle", int'(tx_empty), 0);
            wait_edge(s + 10 * n);
            check(tx_empty == 1'b1, "R4", "tx_empty after stop", int'(tx_empty), 1);
        end

        // R5 R6 R8: hold, ready timing, refused write
        n = 4;
        do_reset(n - 1);
        s = edge_no + 1;
        fork
            begin
                write_at(s, 8'hC3);
                write_at(s + 1, 8'h3C);
                check(tx_ready == 1'b0, "R5", "tx_ready with byte held", int'(tx_ready), 0);
                check(overrun == 1'b0, "R8", "overrun before refusal", int'(overrun), 0);
                write_at(s + 2, 8'hFF);
                check(overrun == 1'b1, "R8", "overrun after refusal", int'(overrun), 1);
                wait_edge(s + 9 * n - 1);
                check(tx_ready == 1'b0, "R6", "tx_ready before stop bit", int'(tx_ready), 0);
                wait_edge(s + 9 * n);
                check(tx_ready == 1'b1, "R6", "tx_ready at stop bit", int'(tx_ready), 1);
            end
            begin
                check_frame(8'hC3, s, n, "R5");
                check_frame(8'h3C, s + 10 * n, n, "R7");
                check_idle(s + 20 * n, 10 * n, "R8");
            end
        join
        check(overrun == 1'b1, "R8", "overrun sticky", int'(overrun), 1);

        // R7: all 256 byte values back to back
        do_reset(n - 1);
        s = edge_no + 1;
        fork
            begin
                for (int v = 0; v < 256; v++) begin
                    while (!tx_ready) @(negedge clk);
                    wr_en   = 1'b1;
                    wr_data = 8'(v);
                    @(negedge clk);
                    wr_en = 1'b0;
                end
            end
            begin
                for (int v = 0; v < 256; v++) begin
                    check_frame(8'(v), s + 10 * n * v, n, "R7");
                end
            end
        join
        check_idle(s + 2560 * n, 10 * n, "R7");
        check(overrun == 1'b0, "R7", "overrun in paced stream", int'(overrun), 0);

        // R9: write at each cycle around the stop-bit end
        for (int off = -(n - 2); off <= 2; off++) begin
            int tc;
            int exp_s;
            do_reset(n - 1);
            s     = edge_no + 1;
            tc    = s + 10 * n + off;
            exp_s = (off <= 0) ? (s + 10 * n) : tc;
            fork
                begin
                    write_at(s, 8'h81);
                    write_at(tc, 8'h6E);
                end
                begin
                    check_frame(8'h81, s, n, "R9");
                    check_frame(8'h6E, exp_s, n, "R9");
                    check_idle(exp_s + 10 * n, 10 * n, "R9");
                end
            join
            check(overrun == 1'b0, "R9", "overrun at handoff", int'(overrun), 0);
        end

        summary();
    end

endmodule